// File: doc/BRIEF.md
# Burst-Counted SPI Flash Read Master

This block is a single-lane SPI master built for fetching data from serial flash. Software-style control inputs select bus enable and master mode and set the SCLK divider. They also empty either FIFO, request a self-clearing soft reset, and launch an exchange. Each exchange is framed by two counts. The burst count is the total number of bytes clocked. The transmit count is how many leading bytes are pulled from the TX FIFO.

Every byte shifted in during the exchange lands in the RX FIFO, including the bytes that arrive while the command and address go out. The host therefore discards the header bytes, using the RX fill level to know when the whole burst has arrived. A typical flash read loads a read opcode and a 24-bit address into the TX FIFO, sets the transmit count to 4 and the burst count to 4 plus the payload length, and pulses start.

Top module: `spi_burst_master`

## Requirements
- R1: One exchange clocks exactly `burst_cnt_i` bytes (8 SCLK pulses each) while `cs_n_o` is low; a start with a burst count of zero does nothing.
- R2: The first `tx_cnt_i` bytes of an exchange are popped from the TX FIFO; later bytes, and any byte needed while the TX FIFO is empty, shift out as 0x00. Bytes go out MSB first.
- R3: Every byte received during the exchange is pushed into the RX FIFO in arrival order. Bits are sampled on the rising SCLK edge, MSB first, and `rx_data_o` shows the oldest entry.
- R4: Both FIFOs hold 64 bytes, and `rx_level_o` is the 7-bit RX fill count (0 to 64).
- R5: A `start_i` pulse accepted while idle raises `busy_o`, which stays high until the final byte completes and then clears by itself. A start pulse during an exchange is ignored.
- R6: `tx_flush_i` empties the TX FIFO; `rx_flush_i` empties the RX FIFO and clears `rx_ovf_o`.
- R7: A `soft_rst_i` pulse holds `srst_busy_o` high for `SRST_CYCLES` cycles. During that window both FIFOs are emptied and any exchange is aborted, after which the flag clears on its own.
- R8: The bus is driven only when both `cfg_en_i` and `cfg_master_i` are 1. Otherwise `cs_n_o` is 1, `sclk_o` and `mosi_o` are 0, and start is ignored.
- R9: SPI mode 0 applies, with SCLK idle low. Each SCLK half period lasts `clk_div_i`+1 clock cycles, so a setting of 1 gives SCLK at a quarter of the clock (6 MHz from 24 MHz). `cs_n_o` falls one half period before the first rising edge.
- R10: A write into a full TX FIFO is discarded, and `tx_full_o` is 1 while the TX FIFO holds 64 bytes.
- R11: When a received byte finds the RX FIFO full, the byte is dropped and the sticky `rx_ovf_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Controller enable |
| cfg_master_i | input | 1 | Master mode select |
| clk_div_i | input | 8 | SCLK half period minus one, in clock cycles |
| tx_flush_i | input | 1 | Empty the TX FIFO (pulse) |
| rx_flush_i | input | 1 | Empty the RX FIFO, clear overflow (pulse) |
| soft_rst_i | input | 1 | Soft reset request (pulse) |
| srst_busy_o | output | 1 | Soft reset in progress |
| start_i | input | 1 | Begin an exchange (pulse) |
| burst_cnt_i | input | 8 | Total bytes to clock |
| tx_cnt_i | input | 8 | Leading bytes taken from the TX FIFO |
| busy_o | output | 1 | Exchange in progress |
| tx_wr_i | input | 1 | TX FIFO write strobe |
| tx_data_i | input | 8 | TX FIFO write data |
| tx_full_o | output | 1 | TX FIFO full |
| rx_rd_i | input | 1 | RX FIFO pop strobe |
| rx_data_o | output | 8 | Oldest RX byte |
| rx_level_o | output | 7 | RX fill level |
| rx_ovf_o | output | 1 | Sticky RX overflow |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is the one where the TX count outruns the TX FIFO contents while the RX FIFO is already full. In that state a single exchange has to hit a discarded write, an empty-FIFO dummy byte and an RX overflow together. The bench fills the TX FIFO to 64, writes one extra byte that must be dropped, and then runs a 65-byte burst with a transmit count of 65. The last transmitted byte must be 0x00, the RX level must stop at 64 and the overflow flag must rise. A soft reset issued mid-burst exercises the abort path. A slave model on the pins then checks that the stale TX data is gone.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       wr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       rd_i,
  output logic [W-1:0]               rdata_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH):0]     level_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_wr, do_rd;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_wr   = wr_i && !full_o && !flush_i;
  assign do_rd   = rd_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_wr) wptr_q <= wptr_q + AW'(1);
      if (do_rd) rptr_q <= rptr_q + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  // full FIFO keeps its level when only a write arrives
  assert_drop_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i && !flush_i) |=> (level_q == $past(level_q)));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             bus_en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] burst_i,
  input  logic [CNT_W-1:0] txcnt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_empty_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  input  logic             miso_i
);
  eng_state_e       state_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [CNT_W-1:0] left_q, txleft_q, txleft_sel;
  logic [2:0]       bit_q;
  logic [7:0]       txsh_q, rxsh_q, byte_nxt;
  logic             tick, act, go, load, use_tx, last_bit;

  assign act        = bus_en_i && !clear_i;
  assign tick       = (cnt_q == '0);
  assign last_bit   = (bit_q == 3'd7);
  assign go         = (state_q == ST_IDLE) && start_i && (burst_i != '0);
  assign load       = go || ((state_q == ST_HIGH) && tick && last_bit && (left_q != CNT_W'(1)));
  assign txleft_sel = (state_q == ST_IDLE) ? txcnt_i : txleft_q;
  assign use_tx     = (txleft_sel != '0) && !tx_empty_i;
  assign byte_nxt   = use_tx ? tx_data_i : 8'h00;
  assign tx_pop_o   = act && load && use_tx;
  assign rx_push_o  = act && (state_q == ST_HIGH) && tick && last_bit;
  assign rx_data_o  = rxsh_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign sclk_o     = (state_q == ST_HIGH);
  assign cs_n_o     = (state_q == ST_IDLE);
  assign mosi_o     = (state_q != ST_IDLE) && txsh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      div_q    <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      txleft_q <= '0;
      bit_q    <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
    end else if (!act) begin
      state_q <= ST_IDLE;
    end else begin
      if (state_q != ST_IDLE && !tick) cnt_q <= cnt_q - DIV_W'(1);
      if (load) begin
        txsh_q   <= byte_nxt;
        txleft_q <= txleft_sel - CNT_W'(txleft_sel != '0);
        bit_q    <= '0;
      end
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_LOW;
          div_q   <= div_i;
          cnt_q   <= div_i;
          left_q  <= burst_i;
        end
        ST_LOW: if (tick) begin
          state_q <= ST_HIGH;
          cnt_q   <= div_q;
          rxsh_q  <= {rxsh_q[6:0], miso_i};
        end
        ST_HIGH: if (tick) begin
          cnt_q <= div_q;
          if (!last_bit) begin
            bit_q   <= bit_q + 3'd1;
            txsh_q  <= {txsh_q[6:0], 1'b0};
            state_q <= ST_LOW;
          end else if (left_q == CNT_W'(1)) begin
            state_q <= ST_TAIL;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            state_q <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_idle_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |=> (cs_n_o && !sclk_o && !mosi_o));
  assert_pop_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);
  assert_div_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && act) |-> $stable(div_q));
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int FIFO_DEPTH  = 64,
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_en_i,
  input  logic                        cfg_master_i,
  input  logic [DIV_W-1:0]            clk_div_i,
  input  logic                        tx_flush_i,
  input  logic                        rx_flush_i,
  input  logic                        soft_rst_i,
  output logic                        srst_busy_o,
  input  logic                        start_i,
  input  logic [CNT_W-1:0]            burst_cnt_i,
  input  logic [CNT_W-1:0]            tx_cnt_i,
  output logic                        busy_o,
  input  logic                        tx_wr_i,
  input  logic [7:0]                  tx_data_i,
  output logic                        tx_full_o,
  input  logic                        rx_rd_i,
  output logic [7:0]                  rx_data_o,
  output logic [$clog2(FIFO_DEPTH):0] rx_level_o,
  output logic                        rx_ovf_o,
  output logic                        sclk_o,
  output logic                        mosi_o,
  output logic                        cs_n_o,
  input  logic                        miso_i
);
  localparam int SW = $clog2(SRST_CYCLES + 1);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic [SW-1:0] srst_cnt_q;
  logic          srst_act, tx_empty, tx_pop, rx_push, rx_full, rx_empty, tx_full_unused;
  logic [7:0]    tx_head, rx_byte;
  logic [LW-1:0] tx_level_unused;
  logic          ovf_q;

  assign srst_act    = (srst_cnt_q != '0);
  assign srst_busy_o = srst_act;
  assign rx_ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     srst_cnt_q <= '0;
    else if (srst_act)               srst_cnt_q <= srst_cnt_q - SW'(1);
    else if (soft_rst_i)             srst_cnt_q <= SW'(SRST_CYCLES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovf_q <= 1'b0;
    else if (srst_act || rx_flush_i) ovf_q <= 1'b0;
    else if (rx_push && rx_full)     ovf_q <= 1'b1;
  end

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (tx_flush_i || srst_act),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_data_i),
    .rd_i    (tx_pop),
    .rdata_o (tx_head),
    .full_o  (tx_full_unused),
    .empty_o (tx_empty),
    .level_o (tx_level_unused)
  );
  assign tx_full_o = tx_full_unused;

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (rx_flush_i || srst_act),
    .wr_i    (rx_push),
    .wdata_i (rx_byte),
    .rd_i    (rx_rd_i),
    .rdata_o (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .level_o (rx_level_o)
  );

  spi_burst_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
    .clk_i, .rst_ni,
    .clear_i    (srst_act),
    .bus_en_i   (cfg_en_i && cfg_master_i),
    .start_i    (start_i),
    .burst_i    (burst_cnt_i),
    .txcnt_i    (tx_cnt_i),
    .div_i      (clk_div_i),
    .tx_empty_i (tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_byte),
    .busy_o     (busy_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_n_o     (cs_n_o),
    .miso_i     (miso_i)
  );

  assert_srst_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_act && $past(srst_act)) |-> (cs_n_o && !busy_o && rx_empty));
  assert_ovf_on_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !srst_act && !rx_flush_i) |=> rx_ovf_o);
endmodule

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int SRST_N     = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 1'b1, master = 1'b1;
  logic [7:0] div = 8'd1;
  logic       tx_flush = 0, rx_flush = 0, soft_rst = 0, start = 0;
  logic [7:0] burst = 0, txc = 0;
  logic       tx_wr = 0, rx_rd = 0;
  logic [7:0] tx_d = 0;
  logic       srst_busy, busy, tx_full, rx_ovf, sclk, mosi, cs_n;
  logic       miso = 1'b0;
  logic [7:0] rx_d;
  logic [6:0] rx_lvl;

  int checks = 0, errors = 0;
  logic [7:0] cap [0:127];
  int ncap = 0, nbit = 0, sidx = 0, sbit = 7;
  logic [7:0] msh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_master #(.SRST_CYCLES(SRST_N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_master_i(master), .clk_div_i(div),
    .tx_flush_i(tx_flush), .rx_flush_i(rx_flush), .soft_rst_i(soft_rst), .srst_busy_o(srst_busy),
    .start_i(start), .burst_cnt_i(burst), .tx_cnt_i(txc), .busy_o(busy),
    .tx_wr_i(tx_wr), .tx_data_i(tx_d), .tx_full_o(tx_full),
    .rx_rd_i(rx_rd), .rx_data_o(rx_d), .rx_level_o(rx_lvl), .rx_ovf_o(rx_ovf),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .miso_i(miso));

  function automatic logic [7:0] resp(input int i);
    return 8'((i * 37 + 5) & 8'hff);
  endfunction

  // slave model: mode 0, presents bits on falling edges, captures MOSI on rising edges
  always @(negedge cs_n) begin sidx = 0; sbit = 7; nbit = 0; miso = resp(0)[7]; end
  always @(negedge sclk) if (!cs_n) begin
    if (sbit == 0) begin sbit = 7; sidx++; end else sbit--;
    miso = resp(sidx)[sbit];
  end
  always @(posedge sclk) begin
    msh = {msh[6:0], mosi}; nbit++;
    if (nbit == 8) begin cap[ncap] = msh; ncap++; nbit = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk) begin tx_wr = 1'b1; tx_d = d; end
    @(negedge clk) tx_wr = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] b, input logic [7:0] t);
    ncap = 0;
    burst = b; txc = t;
    pulse(start);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R8 reset bus idle", {cs_n, sclk}, 2'b10);
    chk(busy === 1'b0 && rx_lvl === 7'd0 && !tx_full && !rx_ovf, "R5 reset state", {busy, rx_lvl}, 0);
  endtask

  task automatic t_read_cmd;
    logic [7:0] hdr [4] = '{8'h03, 8'h12, 8'h34, 8'h56};
    foreach (hdr[i]) push_tx(hdr[i]);
    ncap = 0; burst = 8; txc = 4;
    pulse(start);
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R5 busy during exchange", busy, 1);
    pulse(start); // ignored while busy
    while (busy) @(negedge clk);
    chk(ncap == 8, "R1 byte count", ncap, 8);
    for (int i = 0; i < 8; i++)
      chk(cap[i] == (i < 4 ? hdr[i] : 8'h00), "R2 mosi byte", cap[i], (i < 4 ? hdr[i] : 0));
    chk(rx_lvl == 7'd8, "R3 rx level", rx_lvl, 8);
    for (int i = 0; i < 8; i++) begin
      chk(rx_d == resp(i), "R3 rx byte order", rx_d, resp(i));
      pulse(rx_rd);
    end
    chk(rx_lvl == 0 && cs_n === 1'b1 && busy === 1'b0, "R5 done clears", {rx_lvl, busy}, 0);
  endtask

  task automatic t_zero_burst;
    ncap = 0; burst = 0; txc = 0;
    pulse(start);
    repeat (20) @(negedge clk);
    chk(ncap == 0 && cs_n === 1'b1 && busy === 1'b0, "R1 zero burst idle", ncap, 0);
  endtask

  task automatic t_disabled;
    ncap = 0;
    en = 1'b0; burst = 2; txc = 0;
    pulse(start);
    repeat (20) @(negedge clk);
    chk(ncap == 0 && cs_n === 1'b1 && !busy, "R8 disabled ignores start", ncap, 0);
    en = 1'b1; master = 1'b0;
    pulse(start);
    repeat (20) @(negedge clk);
    chk(ncap == 0 && cs_n === 1'b1 && !busy && !mosi, "R8 slave mode ignores start", ncap, 0);
    master = 1'b1;
    rx_flush = 1'b1; @(negedge clk) rx_flush = 1'b0;
  endtask

  task automatic t_timing(input logic [7:0] d);
    int n = 0, h = 0;
    div = d; burst = 1; txc = 0; ncap = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(cs_n === 1'b0 && sclk === 1'b0, "R9 cs low before clock", {cs_n, sclk}, 0);
    while (!sclk && n < 600) begin @(negedge clk); n++; end
    chk(n == d + 1, "R9 lead half period", n, d + 1);
    while (sclk && h < 600) begin @(negedge clk); h++; end
    chk(h == d + 1, "R9 high half period", h, d + 1);
    while (busy) @(negedge clk);
    div = 8'd1;
    rx_flush = 1'b1; @(negedge clk) rx_flush = 1'b0;
  endtask

  task automatic t_full_fifos;
    for (int i = 0; i < 64; i++) push_tx(8'(8'h40 + i));
    chk(tx_full === 1'b1, "R10 tx full at 64", tx_full, 1);
    push_tx(8'hEE);
    div = 8'd0;
    run_burst(8'd65, 8'd65);
    div = 8'd1;
    chk(ncap == 65, "R1 long burst count", ncap, 65);
    for (int i = 0; i < 64; i++)
      chk(cap[i] == 8'(8'h40 + i), "R10 tx contents", cap[i], 8'h40 + i);
    chk(cap[64] == 8'h00, "R10 dropped write / R2 empty gives 00", cap[64], 0);
    chk(rx_lvl == 7'd64, "R4 rx level caps at 64", rx_lvl, 64);
    chk(rx_ovf === 1'b1, "R11 overflow set", rx_ovf, 1);
    chk(rx_d == resp(0), "R4 oldest kept", rx_d, resp(0));
    pulse(rx_flush);
    chk(rx_lvl == 0 && rx_ovf === 1'b0, "R6 rx flush", {rx_ovf, rx_lvl}, 0);
  endtask

  task automatic t_tx_flush;
    push_tx(8'hA5); push_tx(8'h5A); push_tx(8'hC3);
    pulse(tx_flush);
    chk(tx_full === 1'b0, "R6 tx flush not full", tx_full, 0);
    run_burst(8'd2, 8'd2);
    chk(cap[0] == 8'h00 && cap[1] == 8'h00, "R6 tx flush empties", {cap[0], cap[1]}, 0);
    pulse(rx_flush);
  endtask

  task automatic t_soft_reset;
    int n = 0;
    for (int i = 0; i < 6; i++) push_tx(8'(8'h90 + i));
    burst = 20; txc = 6;
    pulse(start);
    repeat (40) @(negedge clk);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    while (srst_busy && n < 50) begin n++; @(negedge clk); end
    chk(n == SRST_N, "R7 soft reset duration", n, SRST_N);
    chk(cs_n === 1'b1 && !busy && rx_lvl == 0, "R7 abort and rx emptied", {busy, rx_lvl}, 0);
    run_burst(8'd1, 8'd1);
    chk(ncap == 1 && cap[0] == 8'h00, "R7 tx emptied", cap[0], 0);
    pulse(rx_flush);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_cmd();
    t_zero_burst();
    t_disabled();
    t_timing(8'd1);
    t_timing(8'd3);
    t_full_fifos();
    t_tx_flush();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule